// File: doc/BRIEF.md
# Stored-Vector Timing Sequencer

This block plays back a list of timing vectors kept in a small on-chip memory. Each vector pairs an 8-bit control pattern with an 8-bit dwell code. The pattern drives the front-end switch controls of an analog sampling chain, two external trigger lines and an ADC start-of-conversion strobe. A host fills the memory through a write port, can read any entry back through a separate read port, and starts playback with a single trigger write that carries a start index and a vector count.

Once started, the sequencer applies the vectors one after another to a registered output. Each vector is held for its own dwell time, measured in clock periods; at the intended 40 MHz clock one period is 25 ns. After the last vector it returns to idle. A busy flag is high for the whole of playback. On the way out, the convert strobe is removed so the converters do not keep firing. The other control lines keep their last values, so the output never passes through an all-zero pattern.

Top module: `vector_player`

## Requirements
- R1: After reset, `busy` is 0 and `pattern` is 8'h00.
- R2: A host write stores the whole 16-bit word at `wr_addr`, and `rd_data` shows the word at `rd_addr` combinationally. In each word, bits [15:8] are the dwell code and bits [7:0] are the control pattern. Within the pattern, bit 7 is external trigger 2, bit 6 is external trigger 1, bit 5 is front-end reset, bit 4 is DC restore, bit 3 is integrate, bit 2 is non-invert, bit 1 is invert and bit 0 is the convert strobe.
- R3: A trigger sampled while idle sets `busy` at that same clock edge.
- R4: The first vector's pattern appears on `pattern` at the third rising edge after the edge that sampled the trigger. Until then, `pattern` keeps its earlier value.
- R5: A vector with dwell code d stays on `pattern` for exactly d+1 clock cycles, for every d from 0 to 255.
- R6: Playback visits the indices start, start+1, and so on up to start+count−1, with the index wrapping modulo 64. A count of 0 plays all 64 entries.
- R7: When the last vector's dwell ends, `busy` falls. At that same edge, `pattern` takes the last vector's bits [7:1] with bit 0 cleared. No all-zero pattern appears in between.
- R8: A trigger presented while `busy` is high has no effect on the sequence played.
- R9: A host write during playback to an entry at least two positions ahead of the vector on the output is used when that entry is played.
- R10: While idle with no trigger, `pattern` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one dwell unit |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host memory write strobe |
| wr_addr | input | 6 | Host write index |
| wr_data | input | 16 | Host write word: dwell in [15:8], pattern in [7:0] |
| rd_addr | input | 6 | Host read index |
| rd_data | output | 16 | Word stored at rd_addr |
| trig_en | input | 1 | Trigger write strobe |
| trig_start | input | 6 | First index to play |
| trig_count | input | 6 | Number of vectors; 0 means 64 |
| pattern | output | 8 | Registered control pattern |
| busy | output | 1 | High while playback runs |

## Verification
The bench builds the block with its default parameters: 6 index bits, an 8-bit dwell and an 8-bit pattern. With these values the full 64-entry list and the longest 256-cycle dwell can be played within the run. Playback starting at index 60 covers wrap-around, and a count of 0 plays the whole memory. A scoreboard predicts `busy` and `pattern` for every cycle after each trigger. This catches any off-by-one error in the three-cycle start latency or in a dwell, and any intermediate zero pattern on entering or leaving a sequence.

// File: rtl/vector_player.sv
module vector_player #(
  parameter int AW    = 6,
  parameter int DLY_W = 8,
  parameter int CTL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DLY_W+CTL_W-1:0] wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DLY_W+CTL_W-1:0] rd_data,
  input  logic                   trig_en,
  input  logic [AW-1:0]          trig_start,
  input  logic [AW-1:0]          trig_count,
  output logic [CTL_W-1:0]       pattern,
  output logic                   busy
);
  localparam int DEPTH = 1 << AW;
  localparam int WW    = DLY_W + CTL_W;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_LEAD, S_RUN} state_t;

  logic [WW-1:0]    mem [DEPTH];
  state_t           st;
  logic [AW-1:0]    ptr;
  logic [AW:0]      left;
  logic [DLY_W-1:0] timer;
  logic [WW-1:0]    nxt;
  logic [CTL_W-1:0] pat_q;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  assign rd_data = mem[rd_addr];
  assign pattern = pat_q;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= '0;
      left  <= '0;
      timer <= '0;
      nxt   <= '0;
      pat_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (trig_en) begin
          st   <= S_ARM;
          ptr  <= trig_start;
          left <= (trig_count == '0) ? (AW+1)'(DEPTH) : {1'b0, trig_count};
        end
        S_ARM: begin
          nxt <= mem[ptr];
          ptr <= ptr + 1'b1;
          st  <= S_LEAD;
        end
        S_LEAD: begin
          timer <= '0;
          st    <= S_RUN;
        end
        default: begin
          if (timer != '0) begin
            timer <= timer - 1'b1;
          end else if (left != '0) begin
            pat_q <= nxt[CTL_W-1:0];
            timer <= nxt[WW-1:CTL_W];
            left  <= left - 1'b1;
            nxt   <= mem[ptr];
            ptr   <= ptr + 1'b1;
          end else begin
            pat_q[0] <= 1'b0;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module vector_player_chk #(
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_en,
  input logic [CTL_W-1:0] pattern,
  input logic             busy
);
  // R3: idle trigger starts playback
  p_trig_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig_en) |=> busy);
  // R7: leaving playback clears the convert strobe
  p_conv_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !pattern[0]);
  // R7: other controls carry over on exit, no zero glitch
  p_exit_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pattern[CTL_W-1:1] == $past(pattern[CTL_W-1:1]));
  // R10: idle output holds
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(pattern));
  // R4: pattern cannot move on the edge that accepts a trigger
  p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $stable(pattern));
endmodule

bind vector_player vector_player_chk #(.CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .pattern(pattern), .busy(busy));

// File: tb/tb_vector_player.sv
module tb_vector_player;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [5:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [5:0]  rd_addr = 0;
  logic [15:0] rd_data;
  logic        trig_en = 0;
  logic [5:0]  trig_start = 0;
  logic [5:0]  trig_count = 0;
  logic [7:0]  pattern;
  logic        busy;

  vector_player dut (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic b; logic [7:0] p; string req; } item_t;
  item_t       q[$];
  logic [15:0] model [64];
  logic [7:0]  cur_pat = 8'h00;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (busy !== it.b || pattern !== it.p) begin
        n_fail++;
        $display("FAIL %s: busy/pattern %0b/%h expected %0b/%h", it.req, busy, pattern, it.b, it.p);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // push expected cycles, then fire the trigger
  task automatic play(input logic [5:0] start, input logic [5:0] count,
                      input bit late, input logic [5:0] late_idx, input logic [15:0] late_val,
                      input bit extra_trig);
    int n;
    n = (count == 0) ? 64 : count;
    if (late) model[late_idx] = late_val;   // R9 expectation uses the new word
    @(negedge clk);
    for (int k = 0; k < 3; k++) q.push_back('{1'b1, cur_pat, "R4"});
    for (int v = 0; v < n; v++) begin
      logic [15:0] w;
      w = model[6'(start + v)];           // R6 wrap modulo 64
      for (int c = 0; c <= int'(w[15:8]); c++) q.push_back('{1'b1, w[7:0], "R5"});
      cur_pat = w[7:0];
    end
    cur_pat[0] = 1'b0;
    q.push_back('{1'b0, cur_pat, "R7"});
    q.push_back('{1'b0, cur_pat, "R10"});
    trig_en = 1; trig_start = start; trig_count = count;
    @(negedge clk);
    trig_en = 0;
    if (late) begin
      @(negedge clk);
      wr_en = 1; wr_addr = late_idx; wr_data = late_val;
      @(negedge clk);
      wr_en = 0;
    end
    if (extra_trig) begin                 // R8 trigger while busy
      repeat (3) @(negedge clk);
      trig_en = 1; trig_start = 6'd0; trig_count = 6'd1;
      @(negedge clk);
      trig_en = 0;
    end
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++)
      model[i] = {8'(i % 5), 8'(i * 29 + 3)};
    model[10] = {8'hFF, 8'hA5};
    model[12] = {8'h00, 8'hF0};
    repeat (3) @(negedge clk);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 pattern", {8'd0, pattern}, 16'd0);
    rst_n = 1;
    for (int i = 0; i < 64; i++) hw(6'(i), model[i]);
    for (int i = 0; i < 64; i += 9) begin
      rd_addr = 6'(i); #1;
      check("R2 readback", rd_data, model[i]);
    end
    play(6'd0, 6'd4, 0, 0, 0, 0);
    play(6'd8, 6'd5, 0, 0, 0, 0);         // includes dwell 255 and dwell 0
    play(6'd60, 6'd8, 0, 0, 0, 0);        // wraps past 63
    play(6'd2, 6'd1, 0, 0, 0, 0);         // single vector, convert set
    play(6'd1, 6'd1, 0, 0, 0, 0);
    play(6'd30, 6'd10, 1, 6'd37, 16'h0377, 1);
    rd_addr = 6'd37; #1;
    check("R9 readback", rd_data, 16'h0377);
    play(6'd20, 6'd0, 0, 0, 0, 0);        // count 0 plays 64
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule